// File: doc/BRIEF.md
# Rotating Register File with Loop Control

This block is an integer register file whose upper region is addressed through a sliding window, for use by software-pipelined loops. Logical numbers below a static boundary map straight to physical entries. Logical numbers in the upper region are offset by a rotation base, modulo the size of that region. Each loop iteration steps the base down by one. A value written under logical number r in one iteration is then found under r+1 in the next iteration, and no copy is made.

The block also holds the loop counter and the drain (epilogue) counter that drive the rotation. It exposes a short shift register of stage predicates: stage 0 is set while the kernel runs and cleared while the pipeline drains. The loop-step strobe advances the counters and the window without using the general register ports. There are two combinational read ports and one write port that commits on the clock edge.

Top module: `rot_regfile_renamer`

## Requirements
- R1: After reset both counters are zero, the rotation base is zero, every stage predicate is 0, and every register reads 0.
- R2: Logical register 0 always reads 0, and writes to it have no effect.
- R3: Logical registers 1 to 31 are static: a rotation never changes which entry they address.
- R4: Logical register r, with 32 <= r <= 127, addresses physical entry 32 + ((r - 32 + base) mod 96). A rotation decrements the base modulo 96 (0 steps to 95). Data written under r therefore reads under r+1 after one rotation, and data written under 127 reads under 32.
- R5: A write in the same cycle as a rotation is placed through the mapping that held before that rotation.
- R6: A loop step with a nonzero loop counter decrements the loop counter and leaves the drain counter unchanged. It rotates, shifts a 1 into stage predicate bit 0, and drives loopTaken high in that cycle.
- R7: A loop step with a zero loop counter and a nonzero drain counter decrements the drain counter, rotates and shifts a 0 into bit 0. loopTaken is high only if the drain counter was greater than 1.
- R8: A loop step with both counters zero does not rotate and changes no counter or predicate, and loopTaken stays low.
- R9: On every rotation, stage predicate bit k (k >= 1) takes the value that bit k-1 held before that rotation.
- R10: loadCnt loads both counters, clears the rotation base and all stage predicates, and takes priority over a loop step in the same cycle. In that case nothing rotates and loopTaken stays low.
- R11: The two read ports are independent and combinational. A write becomes visible on the reads in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddrA | input | 7 | Logical register number, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdAddrB | input | 7 | Logical register number, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 7 | Logical register number to write |
| wrData | input | 32 | Write data |
| loadCnt | input | 1 | Load both counters and restart the window |
| loopCntIn | input | 8 | Value loaded into the loop counter |
| epiCntIn | input | 8 | Value loaded into the drain counter |
| loopTop | input | 1 | Loop-step strobe at the end of each iteration |
| loopTaken | output | 1 | Loop branch taken in this cycle |
| stagePred | output | 4 | Stage predicates; bit 0 is the newest stage |

## Verification
A wrong rotation base shows up at the read ports in the next cycle. Every later read of the rotating region then returns data from the wrong entry, and the data written under r and read back under r+1 exposes it. A wrong counter value shows up first on loopTaken and on stage predicate bit 0 at the next loop step. It shows up again as an early or late stop, because the window keeps rotating or halts at the wrong iteration. The reference model is compared with all read ports, loopTaken and the stage predicates on every cycle, so such an error is caught within a cycle or two of the step where it appears.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  // Strobes from the loop control to the register datapath.
  typedef struct packed {
    logic rotate;    // step the rotation base and shift the stage predicates
    logic newStage;  // value shifted into stage predicate bit 0
    logic clearAll;  // reset the rotation base and stage predicates
  } rrfStrobe_t;
endpackage

// File: rtl/rrf_loop_ctrl.sv
module rrf_loop_ctrl
  import rrf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loopTop,
  input  logic             loadCnt,
  input  logic [CNT_W-1:0] loopCntIn,
  input  logic [CNT_W-1:0] epiCntIn,
  output rrfStrobe_t       strobe,
  output logic             loopTaken
);
  logic [CNT_W-1:0] loopCnt, epiCnt;
  logic kernelStep, drainStep;

  assign kernelStep = loopTop && !loadCnt && (loopCnt != '0);
  assign drainStep  = loopTop && !loadCnt && (loopCnt == '0) && (epiCnt != '0);

  always_comb begin
    strobe          = '0;
    strobe.clearAll = loadCnt;
    strobe.rotate   = kernelStep || drainStep;
    strobe.newStage = kernelStep;
    loopTaken       = kernelStep || (drainStep && (epiCnt > CNT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loopCnt <= '0;
      epiCnt  <= '0;
    end else if (loadCnt) begin
      loopCnt <= loopCntIn;
      epiCnt  <= epiCntIn;
    end else if (kernelStep) begin
      loopCnt <= loopCnt - CNT_W'(1);
    end else if (drainStep) begin
      epiCnt <= epiCnt - CNT_W'(1);
    end
  end

  // R6: the kernel step consumes exactly one loop count and leaves the drain count alone
  p_kernel_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (loopTop && !loadCnt && loopCnt != '0) |=>
      (loopCnt == $past(loopCnt) - CNT_W'(1)) && $stable(epiCnt));

  // R7: the drain step consumes one drain count with the loop count held at zero
  p_drain_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loopTop && !loadCnt && loopCnt == '0 && epiCnt != '0) |=>
      (epiCnt == $past(epiCnt) - CNT_W'(1)) && (loopCnt == '0));

  // R8: a finished loop neither rotates nor branches
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loopTop && loopCnt == '0 && epiCnt == '0) |-> (!strobe.rotate && !loopTaken));

  // R10: loading wins over a loop step
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    loadCnt |-> (!strobe.rotate && !loopTaken));

  // R6: counters hold when neither strobe is present
  p_counters_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!loopTop && !loadCnt) |=> ($stable(loopCnt) && $stable(epiCnt)));
endmodule

// File: rtl/rrf_datapath.sv
module rrf_datapath
  import rrf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 128,
  parameter int STATIC_REGS = 32,
  parameter int NUM_STAGES  = 4,
  parameter int NUM_RD      = 2,
  localparam int AW         = $clog2(NUM_REGS),
  localparam int ROT_SIZE   = NUM_REGS - STATIC_REGS,
  localparam int BW         = $clog2(ROT_SIZE)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  rrfStrobe_t                     strobe,
  input  logic [NUM_RD-1:0][AW-1:0]      rdAddr,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdData,
  input  logic                           wrEn,
  input  logic [AW-1:0]                  wrAddr,
  input  logic [DATA_W-1:0]              wrData,
  output logic [NUM_STAGES-1:0]          stages
);
  logic [BW-1:0]     rotBase;
  logic [DATA_W-1:0] regs [NUM_REGS];

  // Logical to physical: static region passes through, rotating region adds base mod ROT_SIZE.
  function automatic logic [AW-1:0] mapIdx(input logic [AW-1:0] lg, input logic [BW-1:0] base);
    logic [AW:0] off;
    if (lg < AW'(STATIC_REGS)) return lg;
    off = {1'b0, lg} - (AW+1)'(STATIC_REGS) + (AW+1)'(base);
    if (off >= (AW+1)'(ROT_SIZE)) off = off - (AW+1)'(ROT_SIZE);
    return AW'(off + (AW+1)'(STATIC_REGS));
  endfunction

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdData[p] = (rdAddr[p] == '0) ? '0 : regs[mapIdx(rdAddr[p], rotBase)];

    // R2: logical zero reads zero on every port
    p_zero_read_r2: assert property (@(posedge clk) disable iff (!rstN)
      (rdAddr[p] == '0) |-> (rdData[p] == '0));
  end

  // Write through the mapping held in this cycle (pre-rotation when both coincide).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wrEn && wrAddr != '0) begin
      regs[mapIdx(wrAddr, rotBase)] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) rotBase <= '0;
    else if (strobe.rotate)
      rotBase <= (rotBase == '0) ? BW'(ROT_SIZE - 1) : rotBase - BW'(1);
  end

  if (NUM_STAGES == 1) begin : g_stage_one
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearAll) stages <= '0;
      else if (strobe.rotate)       stages <= strobe.newStage;
    end
  end else begin : g_stage_chain
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearAll) stages <= '0;
      else if (strobe.rotate)       stages <= {stages[NUM_STAGES-2:0], strobe.newStage};
    end

    // R9: older stages inherit their younger neighbour on each rotation
    p_stage_shift_r9: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.rotate && !strobe.clearAll) |=>
        (stages[NUM_STAGES-1:1] == $past(stages[NUM_STAGES-2:0])));
  end

  // R4: the base stays inside the rotating region
  p_base_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    rotBase < BW'(ROT_SIZE));

  // R8: without a rotate or clear the window does not move
  p_base_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rotate && !strobe.clearAll) |=> ($stable(rotBase) && $stable(stages)));

  // R6: stage 0 follows the strobe value after a rotation
  p_stage_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rotate && !strobe.clearAll) |=> (stages[0] == $past(strobe.newStage)));
endmodule

// File: rtl/rot_regfile_renamer.sv
module rot_regfile_renamer
  import rrf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 128,
  parameter int STATIC_REGS = 32,
  parameter int CNT_W       = 8,
  parameter int NUM_STAGES  = 4,
  localparam int AW         = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [AW-1:0]         rdAddrA,
  output logic [DATA_W-1:0]     rdDataA,
  input  logic [AW-1:0]         rdAddrB,
  output logic [DATA_W-1:0]     rdDataB,
  input  logic                  wrEn,
  input  logic [AW-1:0]         wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  loadCnt,
  input  logic [CNT_W-1:0]      loopCntIn,
  input  logic [CNT_W-1:0]      epiCntIn,
  input  logic                  loopTop,
  output logic                  loopTaken,
  output logic [NUM_STAGES-1:0] stagePred
);
  rrfStrobe_t              strobe;
  logic [1:0][DATA_W-1:0]  rdDataArr;

  rrf_loop_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .loopTop(loopTop), .loadCnt(loadCnt),
    .loopCntIn(loopCntIn), .epiCntIn(epiCntIn),
    .strobe(strobe), .loopTaken(loopTaken)
  );

  rrf_datapath #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .STATIC_REGS(STATIC_REGS),
    .NUM_STAGES(NUM_STAGES), .NUM_RD(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdAddr({rdAddrB, rdAddrA}), .rdData(rdDataArr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stages(stagePred)
  );

  assign rdDataA = rdDataArr[0];
  assign rdDataB = rdDataArr[1];
endmodule

// File: tb/rot_regfile_renamer_bench.sv
`timescale 1ns/1ps
module rot_regfile_renamer_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [6:0]  rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData;
  logic        wrEn, loadCnt, loopTop, loopTaken;
  logic [7:0]  loopCntIn, epiCntIn;
  logic [3:0]  stagePred;

  always #2 clk = ~clk; // 250 MHz

  rot_regfile_renamer u_rot_regfile_renamer (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .loadCnt(loadCnt), .loopCntIn(loopCntIn), .epiCntIn(epiCntIn),
    .loopTop(loopTop), .loopTaken(loopTaken), .stagePred(stagePred)
  );

  // Behavioural reference
  int          nVec = 0, nBad = 0;
  bit          finished = 0;
  string       curReq = "R1";
  logic [31:0] mdlMem [128];
  int          mLc = 0, mEc = 0, mBase = 0;
  bit [3:0]    mStage = '0;

  function automatic int physOf(int lg);
    if (lg < 32) return lg;
    return 32 + ((lg - 32 + mBase) % 96);
  endfunction

  function automatic logic [31:0] readOf(int lg);
    if (lg == 0) return 32'h0;
    return mdlMem[physOf(lg)];
  endfunction

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: got %h expected %h", curReq, what, act, exp);
    end
  endtask

  task automatic step(bit we, int wa, logic [31:0] wd, bit lt, bit ld,
                      int lcv, int ecv, int ra, int rb);
    bit expTaken;
    @(negedge clk);
    wrEn = we; wrAddr = 7'(wa); wrData = wd; loopTop = lt; loadCnt = ld;
    loopCntIn = 8'(lcv); epiCntIn = 8'(ecv); rdAddrA = 7'(ra); rdAddrB = 7'(rb);
    #1;
    expTaken = lt && !ld && (mLc != 0 || mEc > 1);
    cmp("portA", rdDataA, readOf(ra));
    cmp("portB", rdDataB, readOf(rb));
    cmp("taken", 32'(loopTaken), 32'(expTaken));
    cmp("stages", 32'(stagePred), 32'(mStage));
    @(posedge clk);
    if (we && wa != 0) mdlMem[physOf(wa)] = wd;   // pre-rotation mapping
    if (ld) begin
      mLc = lcv; mEc = ecv; mBase = 0; mStage = '0;
    end else if (lt && mLc != 0) begin
      mLc--; mBase = (mBase + 95) % 96; mStage = {mStage[2:0], 1'b1};
    end else if (lt && mEc != 0) begin
      mEc--; mBase = (mBase + 95) % 96; mStage = {mStage[2:0], 1'b0};
    end
  endtask

  task automatic rd(int ra, int rb);
    step(0, 0, 0, 0, 0, 0, 0, ra, rb);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mdlMem[i] = '0;
    rstN = 0; wrEn = 0; wrAddr = 0; wrData = 0; loopTop = 0; loadCnt = 0;
    loopCntIn = 0; epiCntIn = 0; rdAddrA = 0; rdAddrB = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    curReq = "R1";  rd(1, 127); rd(64, 32); rd(31, 96);
    curReq = "R2";  step(1, 0, 32'hdead_beef, 0, 0, 0, 0, 0, 0); rd(0, 0);
    curReq = "R11"; step(1, 7, 32'h1111_0007, 0, 0, 0, 0, 7, 7); rd(7, 0);
    curReq = "R10"; step(0, 0, 0, 0, 1, 3, 3, 7, 0);
    curReq = "R3";  step(1, 5, 32'h5555_0005, 0, 0, 0, 0, 0, 0);
    curReq = "R6";  step(0, 0, 0, 1, 0, 0, 0, 5, 0);
    curReq = "R3";  rd(5, 7);
    curReq = "R4";  step(1, 40, 32'h4040_0040, 0, 0, 0, 0, 0, 0);
    curReq = "R6";  step(0, 0, 0, 1, 0, 0, 0, 40, 0);
    curReq = "R4";  rd(41, 40);
    step(1, 127, 32'h7f7f_007f, 0, 0, 0, 0, 0, 0);
    curReq = "R5";  step(1, 50, 32'h5050_0050, 1, 0, 0, 0, 127, 0);
    curReq = "R4";  rd(32, 127);
    curReq = "R5";  rd(51, 50);
    curReq = "R7";  step(0, 0, 0, 1, 0, 0, 0, 51, 0); step(0, 0, 0, 1, 0, 0, 0, 52, 0);
    step(0, 0, 0, 1, 0, 0, 0, 53, 0);
    curReq = "R8";  step(0, 0, 0, 1, 0, 0, 0, 54, 55); rd(54, 55); step(0, 0, 0, 1, 0, 0, 0, 5, 0);
    curReq = "R10"; step(0, 0, 0, 1, 1, 2, 3, 40, 0); rd(40, 41);
    curReq = "R9";  for (int k = 0; k < 7; k++) step(0, 0, 0, 1, 0, 0, 0, 33 + k, 127 - k);
    curReq = "R4";  step(0, 0, 0, 0, 1, 97, 0, 0, 0);
    for (int k = 0; k < 97; k++) step(0, 0, 0, 1, 0, 0, 0, 32 + k, 127 - k);

    curReq = "R11";
    for (int n = 0; n < 600; n++) begin
      bit ld = ($urandom % 16) == 0;
      step(($urandom % 2) == 1, int'($urandom % 128), $urandom,
           ($urandom % 2) == 1, ld, int'($urandom % 6), int'($urandom % 4),
           int'($urandom % 128), int'($urandom % 128));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule